// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Read Responder

This block models a small read-only serial EEPROM of 256 bytes that a host drives by toggling two wire levels, a clock line and a data line. The host does not share a clock with the bus. Instead, each time it wants to present a new pair of levels it raises `strobe` for one cycle with the new levels on `scl_in` and `sda_in`. The block compares them with the pair it stored on the previous strobe, and from that it detects bus start and stop conditions, rising clock edges and unstable data.

A transaction opens with a start condition and is followed by a command byte and an address byte. Each byte is sent most significant bit first and is acknowledged by the block. When the address byte completes, the block latches the addressed byte into its data register. That byte is shifted out, MSB first, on the address edges of the next transaction whose command has bit 0 set.

The memory image comes from a parameter. The host reads back the data line the block holds, together with a progress counter for debugging.

Top module: `i2c_rom_responder`

## Requirements
- R1: A synchronous reset (`rst` high) sets `tick_out` to 0, `sda_out` to 1, the stored clock level to 1 and the acknowledge pending flag to clear.
- R2: A strobe is a bus condition when the stored clock level and `scl_in` are both 1 and `sda_in` differs from the stored data level. A falling data level (start) sets `tick_out` to 1 and clears the command register. A rising data level (stop) leaves `tick_out` unchanged.
- R3: While `tick_out` is 0 and no acknowledge is pending, every strobe other than a start leaves `tick_out` at 0, and `sda_out` takes the value of `sda_in`.
- R4: A strobe with a rising clock (stored 0, `scl_in` 1) while an acknowledge is pending makes `sda_out` 0, clears the pending flag and leaves `tick_out` unchanged.
- R5: A rising clock with no acknowledge pending counts as a data bit only if `sda_in` equals the stored data level. Otherwise `tick_out` is unchanged.
- R6: With `tick_out` from 1 to 8, each data bit is shifted into the command register from the LSB end and `tick_out` increments. On reaching 9, an acknowledge becomes pending.
- R7: With `tick_out` from 9 to 16, each data bit is shifted into the address register and `tick_out` increments. If command bit 0 is 1, `sda_out` shows the MSB of the data register and the data register shifts left. If command bit 0 is 0, `sda_out` takes the value of `sda_in`.
- R8: The data bit that would bring `tick_out` to 17 instead loads the data register with the memory byte at the new address, sets an acknowledge pending and returns `tick_out` to 0.
- R9: Cycles without `strobe` change neither `sda_out`, `tick_out` nor any internal state.
- R10: The default memory image holds byte (i*29+7) mod 256 at address i for i below 128, and 0 at addresses 128 to 255.
- R11: `tick_out` always reports the progress counter, which never exceeds 16 outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Applies the levels on scl_in and sda_in |
| scl_in | input | 1 | Host clock-line level |
| sda_in | input | 1 | Host data-line level |
| sda_out | output | 1 | Data-line level held by the model |
| tick_out | output | 5 | Progress counter (debug) |

## Verification
Several of the block's functions can fall on the same strobe. The clearest case is the eighth address edge of a read. On that edge the block drives the last bit of the old data byte and, in the same update, overwrites the data register with the new memory byte and flags an acknowledge. A start condition can also arrive while an acknowledge is still pending. In that case the start takes effect and the pending acknowledge then consumes the next rising clock. Directed back-to-back read transactions provoke the first case. They are judged by collecting the eight output bits of each read and comparing the byte with the image formula of the previous address. A seeded random level sequence reaches both cases, and each strobe is compared with a bench model written from the requirements.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int IMG_BYTES = 256;
    localparam int IMG_BITS  = 8;

    // Classification of one strobe against the stored line levels
    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_START     = 3'd1,
        EV_STOP      = 3'd2,
        EV_RISE_BIT  = 3'd3,
        EV_RISE_SKEW = 3'd4
    } line_ev_e;

    // Default image: a computed 128-byte table followed by zeros
    function automatic logic [IMG_BYTES*IMG_BITS-1:0] default_image();
        logic [IMG_BYTES*IMG_BITS-1:0] img;
        img = '0;
        for (int i = 0; i < IMG_BYTES / 2; i++) begin
            img[i*IMG_BITS +: IMG_BITS] = IMG_BITS'((i * 29 + 7) % 256);
        end
        return img;
    endfunction

endpackage

// File: rtl/i2cr_line_event.sv
module i2cr_line_event
    import i2cr_pkg::*;
(
    input  logic     scl_prev,
    input  logic     sda_prev,
    input  logic     scl_now,
    input  logic     sda_now,
    output line_ev_e ev
);

    always_comb begin
        ev = EV_NONE;
        if (scl_prev && scl_now && (sda_prev != sda_now)) begin
            ev = sda_now ? EV_STOP : EV_START;
        end else if (!scl_prev && scl_now) begin
            ev = (sda_prev == sda_now) ? EV_RISE_BIT : EV_RISE_SKEW;
        end
    end

endmodule

// File: rtl/i2cr_rom.sv
module i2cr_rom #(
    parameter int                     BYTE_W = 8,
    parameter int                     DEPTH  = 256,
    parameter logic [DEPTH*BYTE_W-1:0] IMAGE = '0
) (
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [BYTE_W-1:0]        rd_data
);

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign cells[g] = IMAGE[g*BYTE_W +: BYTE_W];
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_rom_responder.sv
module i2c_rom_responder
    import i2cr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic [(1<<BYTE_W)*BYTE_W-1:0] ROM_IMAGE = default_image(),
    localparam int DEPTH  = 1 << BYTE_W,
    localparam int TICK_W = $clog2(2 * BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_out,
    output logic [TICK_W-1:0] tick_out
);

    localparam logic [TICK_W-1:0] CMD_DONE  = TICK_W'(BYTE_W + 1);
    localparam logic [TICK_W-1:0] ADDR_DONE = TICK_W'(2 * BYTE_W + 1);

    typedef struct packed {
        logic              scl;
        logic              sda;
        logic [TICK_W-1:0] tick;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic              ack;
    } st_t;

    st_t st_q, st_d;

    line_ev_e          ev;
    logic [BYTE_W-1:0] next_addr;
    logic [BYTE_W-1:0] rom_rd;
    logic [TICK_W-1:0] tick_inc;
    logic              sda_res;

    i2cr_line_event u_ev (
        .scl_prev (st_q.scl),
        .sda_prev (st_q.sda),
        .scl_now  (scl_in),
        .sda_now  (sda_in),
        .ev       (ev)
    );

    assign next_addr = {st_q.addr[BYTE_W-2:0], sda_in};
    assign tick_inc  = st_q.tick + 1'b1;

    i2cr_rom #(
        .BYTE_W (BYTE_W),
        .DEPTH  (DEPTH),
        .IMAGE  (ROM_IMAGE)
    ) u_rom (
        .rd_addr (next_addr),
        .rd_data (rom_rd)
    );

    always_comb begin
        st_d    = st_q;
        sda_res = sda_in;
        if (strobe) begin
            if (ev == EV_START) begin
                st_d.tick = TICK_W'(1);
                st_d.cmd  = '0;
            end else if (ev == EV_STOP) begin
                // stop: counters untouched
            end else if (st_q.tick == '0 && !st_q.ack) begin
                // idle until a start arrives
            end else if (ev == EV_RISE_BIT || ev == EV_RISE_SKEW) begin
                if (st_q.ack) begin
                    sda_res   = 1'b0;
                    st_d.ack  = 1'b0;
                end else if (ev == EV_RISE_BIT) begin
                    if (st_q.tick < CMD_DONE) begin
                        st_d.cmd  = {st_q.cmd[BYTE_W-2:0], sda_in};
                        st_d.tick = tick_inc;
                        if (tick_inc == CMD_DONE) begin
                            st_d.ack = 1'b1;
                        end
                    end else if (st_q.tick < ADDR_DONE) begin
                        if (st_q.cmd[0]) begin
                            sda_res = st_q.data[BYTE_W-1];
                        end
                        st_d.addr = next_addr;
                        st_d.data = {st_q.data[BYTE_W-2:0], 1'b0};
                        st_d.tick = tick_inc;
                        if (tick_inc == ADDR_DONE) begin
                            st_d.data = rom_rd;
                            st_d.ack  = 1'b1;
                            st_d.tick = '0;
                        end
                    end else begin
                        sda_res = 1'b0;
                    end
                end
            end
            st_d.scl = scl_in;
            st_d.sda = sda_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.scl <= 1'b1;
            st_q.sda <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_out  = st_q.sda;
    assign tick_out = st_q.tick;

endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker #(
    parameter int TICK_W    = 5,
    parameter int LAST_TICK = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe,
    input logic              scl_in,
    input logic              sda_in,
    input logic              sda_out,
    input logic [TICK_W-1:0] tick_out,
    input logic              held_scl,
    input logic              ack_pend
);

    logic start_cond;
    assign start_cond = held_scl && scl_in && sda_out && !sda_in;

    // R1
    a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tick_out == '0 && sda_out && held_scl && !ack_pend));

    // R2
    a_r2_start_tick: assert property (@(posedge clk) disable iff (rst)
        (strobe && start_cond) |=> (tick_out == TICK_W'(1)));

    // R3
    a_r3_idle_ignored: assert property (@(posedge clk) disable iff (rst)
        (strobe && tick_out == '0 && !ack_pend && !start_cond)
        |=> (tick_out == '0 && sda_out == $past(sda_in)));

    // R4
    a_r4_ack_low: assert property (@(posedge clk) disable iff (rst)
        (strobe && ack_pend && !held_scl && scl_in) |=> (!sda_out && !ack_pend));

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(tick_out) && $stable(sda_out) && $stable(ack_pend)));

    // R11
    a_r11_tick_bound: assert property (@(posedge clk) disable iff (rst)
        tick_out <= TICK_W'(LAST_TICK));

endmodule

bind i2c_rom_responder i2cr_checker #(
    .TICK_W    (TICK_W),
    .LAST_TICK (2 * BYTE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_out  (sda_out),
    .tick_out (tick_out),
    .held_scl (st_q.scl),
    .ack_pend (st_q.ack)
);

// File: tb/i2c_rom_responder_bench.sv
`timescale 1ns/1ps
module i2c_rom_responder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       sda_out;
    logic [4:0] tick_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    // bench model state, written from the requirements
    logic       m_scl, m_sda, m_ack;
    logic [4:0] m_tick;
    logic [7:0] m_cmd, m_addr, m_data;

    always #5 clk = ~clk;

    i2c_rom_responder u_i2c_rom_responder (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_out  (sda_out),
        .tick_out (tick_out)
    );

    function automatic logic [7:0] rom_byte(input int a);
        return (a < 128) ? 8'((a * 29 + 7) % 256) : 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_scl = 1; m_sda = 1; m_ack = 0; m_tick = 0;
        m_cmd = 0; m_addr = 0; m_data = 0;
    endtask

    task automatic model_step(input logic s, input logic d);
        logic nd;
        nd = d;
        if (m_scl && s && (m_sda != d)) begin
            if (!d) begin m_tick = 1; m_cmd = 0; end
        end else if (m_tick == 0 && !m_ack) begin
        end else if (!m_scl && s) begin
            if (m_ack) begin
                nd = 0; m_ack = 0;
            end else if (m_sda == d) begin
                if (m_tick < 9) begin
                    m_cmd = {m_cmd[6:0], d};
                    m_tick++;
                    if (m_tick == 9) m_ack = 1;
                end else if (m_tick < 17) begin
                    if (m_cmd[0]) nd = m_data[7];
                    m_addr = {m_addr[6:0], d};
                    m_data = m_data << 1;
                    m_tick++;
                    if (m_tick == 17) begin
                        m_data = rom_byte(int'(m_addr));
                        m_ack  = 1;
                        m_tick = 0;
                    end
                end else begin
                    nd = 0;
                end
            end
        end
        m_scl = s;
        m_sda = nd;
    endtask

    // one strobe; outputs sampled at the following falling edge
    task automatic pins(input logic s, input logic d);
        @(negedge clk);
        scl_in = s; sda_in = d; strobe = 1'b1;
        model_step(s, d);
        @(negedge clk);
        strobe = 1'b0;
        check(sda_out === m_sda, "R11 model sda_out", int'(sda_out), int'(m_sda));
        check(tick_out === m_tick, "R11 model tick_out", int'(tick_out), int'(m_tick));
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        pins(1'b0, b);
        pins(1'b1, b);
        seen = sda_out;
        pins(1'b0, b);
    endtask

    task automatic start_cond();
        pins(1'b0, 1'b1);
        pins(1'b1, 1'b1);
        pins(1'b1, 1'b0);
    endtask

    task automatic stop_cond();
        pins(1'b0, 1'b0);
        pins(1'b1, 1'b0);
        pins(1'b1, 1'b1);
    endtask

    // full transaction; returns the eight bits shown during the address phase
    task automatic transact(input logic [7:0] cmd, input logic [7:0] adr,
                            output logic [7:0] shown);
        logic seen;
        start_cond();
        check(tick_out == 5'd1, "R2 start sets tick", int'(tick_out), 1);
        for (int i = 7; i >= 0; i--) clock_bit(cmd[i], seen);
        check(tick_out == 5'd9, "R6 tick after command", int'(tick_out), 9);
        clock_bit(1'b1, seen);
        check(seen == 1'b0, "R4 command acknowledge low", int'(seen), 0);
        check(tick_out == 5'd9, "R4 ack keeps tick", int'(tick_out), 9);
        for (int i = 7; i >= 0; i--) begin
            clock_bit(adr[i], seen);
            shown[i] = seen;
            if (!cmd[0]) check(seen == adr[i], "R7 write command echoes sda_in", int'(seen), int'(adr[i]));
        end
        check(tick_out == 5'd0, "R8 tick returns to zero", int'(tick_out), 0);
        clock_bit(1'b1, seen);
        check(seen == 1'b0, "R8 address acknowledge low", int'(seen), 0);
        stop_cond();
        check(tick_out == 5'd0, "R2 stop leaves tick", int'(tick_out), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] shown;
        logic       seen;
        logic       s, d;
        void'($urandom(32'h1C2E_0417));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tick_out == 5'd0, "R1 reset tick", int'(tick_out), 0);
        check(sda_out == 1'b1, "R1 reset sda_out", int'(sda_out), 1);

        // R9: no strobe, no change
        sda_in = 1'b0; scl_in = 1'b0;
        repeat (4) @(negedge clk);
        check(sda_out == 1'b1 && tick_out == 5'd0, "R9 idle without strobe",
              int'({sda_out, tick_out}), 32);

        // R3: idle activity without a start
        for (int i = 0; i < 6; i++) begin
            clock_bit(1'(i % 2), seen);
            check(tick_out == 5'd0, "R3 idle tick stays zero", int'(tick_out), 0);
            check(seen == 1'(i % 2), "R3 idle sda follows input", int'(seen), i % 2);
        end

        // R7 R8 R10: back-to-back reads show the byte of the previous address
        transact(8'hA1, 8'h05, shown);
        check(shown == 8'h00, "R7 first read shows reset data", int'(shown), 0);
        transact(8'hA1, 8'h7F, shown);
        check(shown == rom_byte(5), "R10 read of address 0x05", int'(shown), int'(rom_byte(5)));
        transact(8'hA0, 8'h90, shown);
        transact(8'hA1, 8'h00, shown);
        check(shown == 8'h00, "R10 upper half reads zero", int'(shown), 0);
        transact(8'hA1, 8'h33, shown);
        check(shown == rom_byte(0), "R10 read of address 0x00", int'(shown), int'(rom_byte(0)));
        transact(8'hA1, 8'h7F, shown);
        check(shown == rom_byte(8'h33), "R8 read of address 0x33", int'(shown), int'(rom_byte(8'h33)));

        // R5: data change across the rising clock is ignored
        start_cond();
        clock_bit(1'b1, seen);
        clock_bit(1'b0, seen);
        pins(1'b0, 1'b1);
        pins(1'b1, 1'b0);
        check(tick_out == 5'd3, "R5 skewed edge ignored", int'(tick_out), 3);
        // R2: stop in the middle of a command keeps the count
        pins(1'b1, 1'b1);
        check(tick_out == 5'd3, "R2 stop keeps mid count", int'(tick_out), 3);
        stop_cond();

        // R11: seeded random level sequence against the model
        s = scl_in; d = sda_in;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 4 != 0) s = ~s;
            if ($urandom % 4 == 0) d = ~d;
            pins(s, d);
            repeat ($urandom % 3) @(negedge clk);
            check(sda_out === m_sda, "R9 hold between strobes", int'(sda_out), int'(m_sda));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule